// File: doc/BRIEF.md
# Register Bus Datapath

This block is the register and arithmetic core of a microcoded processor. A bank of 32-bit registers and an 8-bit fetch buffer share one source bus (the B bus). A dedicated operand register always feeds the ALU's first input. The ALU result passes through a small shifter onto a result bus (the C bus), and any subset of the writable registers captures that value on the next rising clock edge. Each cycle a controller supplies a 4-bit source code, a 9-bit write-enable vector, six ALU control bits and two shift control bits. The block computes a full register-to-register step within that one cycle.

Two data streams arrive from memory: a 32-bit word for the memory data register and a byte for the fetch buffer. Each is a valid-qualified push. The block has no ready signal because it accepts a word in every cycle and never applies back-pressure. A pushed word is taken on the rising edge where its valid bit is high. When a memory word and a C-bus write target the memory data register in the same cycle, the memory word is stored. The flags register records whether the last ALU result was negative or zero. The memory sequencing and the microcode sequencer sit outside this block.

Top module: `regbus_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register, the fetch buffer and both flags clear to zero.
- R2: `b_sel` picks the single B-bus source. Code 0 is the memory data register, codes 3 to 8 are general registers g1 to g6, and codes 9 to 15 drive zero onto the bus.
- R3: `b_sel` code 1 drives the fetch byte sign-extended to 32 bits, and code 2 drives it zero-extended.
- R4: `c_we` bit 0 writes the operand register, bits 1 to 6 write g1 to g6, bit 7 writes the memory data register and bit 8 writes the address register. All enabled registers capture the same C value on one edge, and registers whose bit is clear keep their value.
- R5: The ALU's A input is always the operand register `areg_q`, and it never depends on `b_sel`.
- R6: `alu_ctl` is {F0,F1,ENA,ENB,INVA,INC} from bit 5 down to bit 0. A is masked by ENA and then inverted by INVA, and B is masked by ENB. F0F1 = 00 gives A AND B, 01 gives A OR B, 10 gives NOT B, and 11 gives A+B+INC.
- R7: `sh_ctl` bit 1 shifts the ALU result left by 8 and bit 0 shifts it arithmetically right by 1. Both bits set gives the unshifted result. `c_bus` shows the shifter output within the same cycle.
- R8: At every rising edge out of reset, `flag_n` takes bit 31 of the ALU result before the shifter and `flag_z` takes whether that result is zero.
- R9: A high `mem_valid` loads `mem_data` into the memory data register on that edge, and it takes priority over `c_we` bit 7.
- R10: A high `fetch_valid` loads `fetch_data` into the fetch buffer on that edge. Without it, the buffer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| b_sel | input | 4 | B-bus source code |
| c_we | input | 9 | C-bus write enables |
| alu_ctl | input | 6 | ALU control {F0,F1,ENA,ENB,INVA,INC} |
| sh_ctl | input | 2 | Shift control {left8, arith right1} |
| mem_valid | input | 1 | Memory word push valid |
| mem_data | input | 32 | Memory word |
| fetch_valid | input | 1 | Fetch byte push valid |
| fetch_data | input | 8 | Fetch byte |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| c_bus | output | 32 | Current shifter output |
| areg_q | output | 32 | Operand register |
| g_q | output | 192 | General registers g1..g6, g1 in bits 31:0 |
| mdat_q | output | 32 | Memory data register |
| madr_q | output | 32 | Memory address register |
| fetch_q | output | 8 | Fetch buffer |

## Verification
The bench uses fetch bytes with the top bit set and clear. If the two extension codes were swapped or mixed up, the upper 24 bits of the B bus would be wrong. It also reads the unused source codes, where a wrong decoder would leak a register onto the bus. It shifts a value whose shifted form is negative but whose unshifted form is positive, so a design that takes its flags after the shifter would set N by mistake. It also drives a memory word and a C write into the memory data register in the same cycle, where wrong priority would store the ALU value. Subtraction and the all-ones constant exercise INVA and INC, and a design that ignored the carry-in would be off by one.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef struct packed {
    logic f0;
    logic f1;
    logic ena;
    logic enb;
    logic inva;
    logic inc;
  } alu_ctl_t;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  localparam int unsigned BS_MDAT  = 0;
  localparam int unsigned BS_FSX   = 1;
  localparam int unsigned BS_FZX   = 2;
  localparam int unsigned BS_GBASE = 3;

endpackage

// File: rtl/dp_bsrc.sv
module dp_bsrc #(
  parameter int unsigned DW   = 32,
  parameter int unsigned FW   = 8,
  parameter int unsigned NGPR = 6,
  parameter int unsigned SELW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SELW-1:0]           sel,
  input  logic [DW-1:0]             mdat,
  input  logic [FW-1:0]             fetch,
  input  logic [NGPR-1:0][DW-1:0]   gpr,
  output logic [DW-1:0]             bus
);
  import dp_pkg::*;

  localparam int unsigned NCODE = 1 << SELW;
  localparam int unsigned NSRC  = BS_GBASE + NGPR;

  logic [NCODE-1:0]         hot;
  logic [NSRC-1:0][DW-1:0]  src;

  always_comb begin
    hot = '0;
    hot[sel] = 1'b1;
  end

  assign src[BS_MDAT] = mdat;
  assign src[BS_FSX]  = {{(DW-FW){fetch[FW-1]}}, fetch};
  assign src[BS_FZX]  = {{(DW-FW){1'b0}}, fetch};

  for (genvar g = 0; g < NGPR; g++) begin : g_src
    assign src[BS_GBASE+g] = gpr[g];
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      bus = bus | ({DW{hot[i]}} & src[i]);
    end
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NSRC) |-> (bus == '0));

  // R3
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) == BS_FSX) |-> (bus[DW-1:FW] == {(DW-FW){fetch[FW-1]}} && bus[FW-1:0] == fetch));

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  dp_pkg::alu_ctl_t ctl,
  output logic [DW-1:0]    y
);
  import dp_pkg::*;

  logic [DW-1:0] a_m;
  logic [DW-1:0] b_m;
  alu_fn_e       fn;

  assign fn  = alu_fn_e'({ctl.f0, ctl.f1});
  assign a_m = (ctl.ena ? a : '0) ^ {DW{ctl.inva}};
  assign b_m = ctl.enb ? b : '0;

  always_comb begin
    unique case (fn)
      FN_AND:  y = a_m & b_m;
      FN_OR:   y = a_m | b_m;
      FN_NOTB: y = ~b_m;
      FN_ADD:  y = a_m + b_m + {{(DW-1){1'b0}}, ctl.inc};
      default: y = '0;
    endcase
  end

  // R6
  notb_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl.f0, ctl.f1} == 2'b10 && !ctl.enb) |-> (y == '1));

  // R6
  and_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl.f0, ctl.f1} == 2'b00 && !ctl.enb) |-> (y == '0));

endmodule

// File: rtl/dp_shift.sv
module dp_shift #(
  parameter int unsigned DW  = 32,
  parameter int unsigned LSH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic [1:0]    ctl,
  output logic [DW-1:0] dout
);

  always_comb begin
    unique case (ctl)
      2'b10:   dout = din << LSH;
      2'b01:   dout = {din[DW-1], din[DW-1:1]};
      default: dout = din;
    endcase
  end

  // R7
  both_set_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 2'b11) |-> (dout == din));

endmodule

// File: rtl/dp_regbank.sv
module dp_regbank #(
  parameter int unsigned DW   = 32,
  parameter int unsigned FW   = 8,
  parameter int unsigned NGPR = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NGPR+2:0]          we,
  input  logic [DW-1:0]            c_in,
  input  logic                     mem_valid,
  input  logic [DW-1:0]            mem_data,
  input  logic                     fetch_valid,
  input  logic [FW-1:0]            fetch_data,
  output logic [NGPR+2:0][DW-1:0]  q,
  output logic [FW-1:0]            fetch_q
);

  localparam int unsigned NWE      = NGPR + 3;
  localparam int unsigned IDX_MDAT = NGPR + 1;

  for (genvar i = 0; i < NWE; i++) begin : g_reg
    if (i == IDX_MDAT) begin : g_mem
      always_ff @(posedge clk) begin
        if (!rst_n)         q[i] <= '0;
        else if (mem_valid) q[i] <= mem_data;
        else if (we[i])     q[i] <= c_in;
      end
      // R9
      mem_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> (q[i] == $past(mem_data)));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)      q[i] <= '0;
        else if (we[i])  q[i] <= c_in;
      end
    end
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we[i] && !(i == IDX_MDAT && mem_valid)) |=> $stable(q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           fetch_q <= '0;
    else if (fetch_valid) fetch_q <= fetch_data;
  end

  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(fetch_q));

endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath #(
  parameter int unsigned DW   = 32,
  parameter int unsigned FW   = 8,
  parameter int unsigned NGPR = 6,
  parameter int unsigned SELW = 4,
  parameter int unsigned LSH  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SELW-1:0]         b_sel,
  input  logic [NGPR+2:0]         c_we,
  input  logic [5:0]              alu_ctl,
  input  logic [1:0]              sh_ctl,
  input  logic                    mem_valid,
  input  logic [DW-1:0]           mem_data,
  input  logic                    fetch_valid,
  input  logic [FW-1:0]           fetch_data,
  output logic                    flag_n,
  output logic                    flag_z,
  output logic [DW-1:0]           c_bus,
  output logic [DW-1:0]           areg_q,
  output logic [NGPR-1:0][DW-1:0] g_q,
  output logic [DW-1:0]           mdat_q,
  output logic [DW-1:0]           madr_q,
  output logic [FW-1:0]           fetch_q
);
  import dp_pkg::*;

  localparam int unsigned NWE      = NGPR + 3;
  localparam int unsigned IDX_AREG = 0;
  localparam int unsigned IDX_MDAT = NGPR + 1;
  localparam int unsigned IDX_MADR = NGPR + 2;

  logic [NWE-1:0][DW-1:0] rq;
  logic [DW-1:0]          b_bus;
  logic [DW-1:0]          alu_y;
  alu_ctl_t               ctl_s;

  assign ctl_s = alu_ctl_t'(alu_ctl);

  dp_regbank #(.DW(DW), .FW(FW), .NGPR(NGPR)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(c_we), .c_in(c_bus),
    .mem_valid(mem_valid), .mem_data(mem_data),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .q(rq), .fetch_q(fetch_q)
  );

  assign areg_q = rq[IDX_AREG];
  assign mdat_q = rq[IDX_MDAT];
  assign madr_q = rq[IDX_MADR];

  for (genvar g = 0; g < NGPR; g++) begin : g_out
    assign g_q[g] = rq[1+g];
  end

  dp_bsrc #(.DW(DW), .FW(FW), .NGPR(NGPR), .SELW(SELW)) u_bsrc (
    .clk(clk), .rst_n(rst_n), .sel(b_sel), .mdat(mdat_q),
    .fetch(fetch_q), .gpr(g_q), .bus(b_bus)
  );

  dp_alu #(.DW(DW)) u_alu (
    .clk(clk), .rst_n(rst_n), .a(areg_q), .b(b_bus), .ctl(ctl_s), .y(alu_y)
  );

  dp_shift #(.DW(DW), .LSH(LSH)) u_shift (
    .clk(clk), .rst_n(rst_n), .din(alu_y), .ctl(sh_ctl), .dout(c_bus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      flag_n <= alu_y[DW-1];
      flag_z <= (alu_y == '0);
    end
  end

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);

  // R5
  pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_ctl == 6'b011000 && sh_ctl == 2'b00) |-> (c_bus == areg_q));

endmodule

// File: tb/regbus_datapath_tb.sv
module regbus_datapath_tb;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        b_sel = '0;
  logic [8:0]        c_we = '0;
  logic [5:0]        alu_ctl = '0;
  logic [1:0]        sh_ctl = '0;
  logic              mem_valid = 1'b0;
  logic [31:0]       mem_data = '0;
  logic              fetch_valid = 1'b0;
  logic [7:0]        fetch_data = '0;
  logic              flag_n, flag_z;
  logic [31:0]       c_bus, areg_q, mdat_q, madr_q;
  logic [5:0][31:0]  g_q;
  logic [7:0]        fetch_q;

  int checks = 0;
  int failures = 0;

  localparam logic [5:0] PASSB = 6'b010100;
  localparam logic [5:0] PASSA = 6'b011000;

  logic [31:0] gval [6] = '{32'h0000_0005, 32'hFFFF_FFF0, 32'h00F0_0F00,
                            32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000};

  always #2 clk = ~clk;

  regbus_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .b_sel(b_sel), .c_we(c_we), .alu_ctl(alu_ctl),
    .sh_ctl(sh_ctl), .mem_valid(mem_valid), .mem_data(mem_data),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .flag_n(flag_n),
    .flag_z(flag_z), .c_bus(c_bus), .areg_q(areg_q), .g_q(g_q),
    .mdat_q(mdat_q), .madr_q(madr_q), .fetch_q(fetch_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] bs, input logic [8:0] we,
                       input logic [5:0] ac, input logic [1:0] sh);
    @(negedge clk);
    b_sel = bs; c_we = we; alu_ctl = ac; sh_ctl = sh;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    b_sel = '0; c_we = '0; alu_ctl = '0; sh_ctl = '0;
    mem_valid = 1'b0; fetch_valid = 1'b0;
  endtask

  task automatic load_mem(input logic [31:0] v);
    drive(4'd0, 9'd0, 6'd0, 2'd0);
    mem_valid = 1'b1; mem_data = v;
    tick();
  endtask

  task automatic t_reset();
    chk("R1", "areg", areg_q, 32'h0);
    chk("R1", "mdat", mdat_q, 32'h0);
    chk("R1", "madr", madr_q, 32'h0);
    chk("R1", "g6", g_q[5], 32'h0);
    chk("R1", "fetch", {24'h0, fetch_q}, 32'h0);
    chk("R1", "flags", {30'h0, flag_n, flag_z}, 32'h0);
  endtask

  task automatic t_loads();
    load_mem(32'h1234_5678);
    chk("R9", "mdat load", mdat_q, 32'h1234_5678);
    drive(4'd0, 9'd0, 6'd0, 2'd0);
    fetch_valid = 1'b1; fetch_data = 8'h9C;
    tick();
    chk("R10", "fetch load", {24'h0, fetch_q}, 32'h9C);
    drive(4'd0, 9'd0, 6'd0, 2'd0);
    fetch_data = 8'h11;
    tick();
    chk("R10", "fetch hold", {24'h0, fetch_q}, 32'h9C);
  endtask

  task automatic t_multi();
    drive(4'd0, 9'b1_0111_1110, PASSB, 2'd0);
    tick();
    for (int k = 0; k < 6; k++) chk("R4", "multi write g", g_q[k], 32'h1234_5678);
    chk("R4", "multi write madr", madr_q, 32'h1234_5678);
    chk("R4", "areg untouched", areg_q, 32'h0);
    for (int k = 0; k < 6; k++) begin
      load_mem(gval[k]);
      drive(4'd0, 9'(1 << (k + 1)), PASSB, 2'd0);
      tick();
    end
    for (int k = 0; k < 6; k++) chk("R4", "single write g", g_q[k], gval[k]);
  endtask

  task automatic t_bsel();
    for (int k = 0; k < 6; k++) begin
      drive(4'(3 + k), 9'd0, PASSB, 2'd0);
      chk("R2", "gpr on B", c_bus, gval[k]);
      tick();
    end
    drive(4'd0, 9'd0, PASSB, 2'd0);
    chk("R2", "mdat on B", c_bus, gval[5]);
    tick();
    for (int c = 9; c < 16; c++) begin
      drive(4'(c), 9'd0, PASSB, 2'd0);
      chk("R2", "unused code zero", c_bus, 32'h0);
      tick();
    end
  endtask

  task automatic t_ext();
    drive(4'd1, 9'd0, PASSB, 2'd0);
    chk("R3", "sign ext neg", c_bus, 32'hFFFF_FF9C);
    tick();
    drive(4'd2, 9'd0, PASSB, 2'd0);
    chk("R3", "zero ext neg", c_bus, 32'h0000_009C);
    tick();
    drive(4'd0, 9'd0, 6'd0, 2'd0);
    fetch_valid = 1'b1; fetch_data = 8'h5A;
    tick();
    drive(4'd1, 9'd0, PASSB, 2'd0);
    chk("R3", "sign ext pos", c_bus, 32'h0000_005A);
    tick();
  endtask

  task automatic alu_case(input string nm, input logic [5:0] ac, input logic [31:0] exp);
    drive(4'd4, 9'd0, ac, 2'd0);
    chk("R6", nm, c_bus, exp);
    tick();
    chk("R8", {nm, " Z"}, {31'h0, flag_z}, {31'h0, exp == 32'h0});
    chk("R8", {nm, " N"}, {31'h0, flag_n}, {31'h0, exp[31]});
  endtask

  task automatic t_alu();
    drive(4'd3, 9'd1, PASSB, 2'd0);
    tick();
    chk("R4", "areg write", areg_q, 32'h5);
    drive(4'd9, 9'd0, PASSA, 2'd0);
    chk("R5", "A is areg", c_bus, 32'h5);
    tick();
    alu_case("and", 6'b001100, 32'h0000_0000);
    alu_case("or",  6'b011100, 32'hFFFF_FFF5);
    alu_case("notb", 6'b100100, 32'h0000_000F);
    alu_case("add", 6'b111100, 32'hFFFF_FFF5);
    alu_case("add inc", 6'b111101, 32'hFFFF_FFF6);
    alu_case("b minus a", 6'b111111, 32'hFFFF_FFEB);
    alu_case("minus one", 6'b110010, 32'hFFFF_FFFF);
  endtask

  task automatic t_shift();
    drive(4'd5, 9'd0, PASSB, 2'b10);
    chk("R7", "sll8", c_bus, 32'hF00F_0000);
    tick();
    chk("R8", "N from pre-shift", {31'h0, flag_n}, 32'h0);
    drive(4'd6, 9'd0, PASSB, 2'b01);
    chk("R7", "sra1 neg", c_bus, 32'hC000_0000);
    tick();
    drive(4'd7, 9'd0, PASSB, 2'b01);
    chk("R7", "sra1 pos", c_bus, 32'h3FFF_FFFF);
    tick();
    drive(4'd5, 9'd0, PASSB, 2'b11);
    chk("R7", "both set no shift", c_bus, 32'h00F0_0F00);
    tick();
  endtask

  task automatic t_prio();
    drive(4'd3, 9'b1_1000_0000, PASSB, 2'd0);
    mem_valid = 1'b1; mem_data = 32'hCAFE_F00D;
    tick();
    chk("R9", "mem over C", mdat_q, 32'hCAFE_F00D);
    chk("R4", "madr same cycle", madr_q, 32'h5);
    for (int k = 0; k < 6; k++) chk("R4", "g hold", g_q[k], gval[k]);
    chk("R4", "areg hold", areg_q, 32'h5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_loads();
    t_multi();
    t_bsel();
    t_ext();
    t_alu();
    t_shift();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule